// File: doc/BRIEF.md
# Serial Port with Bus Register Access and Data Queues

This block is a byte-oriented asynchronous serial port that sits on an APB slave port. Software selects the frame shape through a three-bit control register: 7 or 8 data bits, whether a parity bit is present, and whether that parity is even or odd. Bytes written to the transmit offset are queued and sent one frame after another on a single output line. Frames arriving on the input line are checked, queued and read back by software one at a time.

Each frame is a low start bit, then the data bits least significant first, then the optional parity bit, then one high stop bit. The line idles high. The bit time is fixed at 16 sample ticks, and each tick lasts `DIV` clocks, so one bit takes 16*DIV clocks. The receiver confirms each start bit at its centre and samples every later bit at its centre. Two status outputs tell software when it may write and when a character is waiting. A sticky error register records parity, framing and overrun events.

Top module: `sport_top`

## Requirements
- R1: The control register is at byte offset 0xC. Bit 0 set selects 8 data bits (clear selects 7), bit 1 enables parity, and bit 2 set selects odd parity (clear selects even). A read of 0xC returns these three bits in bits 2:0 with zeros above them. The register changes only when software writes offset 0xC.
- R2: An APB write to offset 0x0 queues pwdata[7:0] for sending. A write made while the transmit queue is full is dropped.
- R3: An APB read of offset 0x4 returns the oldest received character in arrival order and removes it. A read while nothing is waiting returns 0 and removes nothing.
- R4: tx_ready is high exactly when the transmit queue has a free entry. It goes low only after a write to offset 0x0.
- R5: rx_avail is high exactly when at least one received character is waiting. It goes low only after a read of offset 0x4, or on reset.
- R6: Each sent frame is a start bit (0), then the data bits LSB first, then the optional parity bit, then a stop bit (1). Every bit lasts 16*DIV clocks. txd is 1 whenever no frame is being sent.
- R7: In 7-bit mode, bit 7 of a queued byte is not sent, and received characters read back with bit 7 equal to 0.
- R8: Even parity makes the total number of ones in the data bits plus the parity bit even. Odd parity makes that total odd.
- R9: A stream of DEPTH+1 characters written back to back, with txd looped to rxd, arrives complete and in order in every mode.
- R10: A low pulse on rxd that is already high again at the centre of the start bit is ignored. It stores no character and sets no error.
- R11: Offset 0x8 reads error flags: bit 0 parity error, bit 1 framing error (stop bit sampled low), bit 2 overrun (a character arrives while the receive queue is full, and that character is dropped). The flags are sticky and a read of 0x8 clears them. A character with a parity or framing error is still stored.
- R12: rst_n is active low and asynchronous. It empties both queues, stops any frame in progress (txd returns to 1), clears the error flags and sets the control register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | AW | APB byte address |
| pwdata | input | 8 | APB write data |
| prdata | output | 8 | APB read data |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| rx_avail | output | 1 | A received character is waiting |

## Verification
On every clock edge the assertions check the following. The idle line is high, and a frame begins with a low start bit. tx_ready and rx_avail fall only after the bus access that can cause them to fall. The control register changes only on a control write. The error flags stay sticky until a read of 0x8, and that read clears them. Bit order and timing, parity sense, 7-bit truncation, in-order delivery through full queues, rejection of false starts, overrun dropping and mid-frame reset can only be shown by the bench scenarios. The bench drives frames and compares the characters that come back against values it computes.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;

   // control register layout: bit 2 odd, bit 1 parity enable, bit 0 eight bits
   typedef struct packed {
      logic odd;
      logic par_en;
      logic eight;
   } ctrl_t;

   typedef struct packed {
      logic [10:0] bits;
      logic [3:0]  len;
   } frame_t;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

   localparam int OFS_TXD = 'h0;
   localparam int OFS_RXD = 'h4;
   localparam int OFS_ERR = 'h8;
   localparam int OFS_CTL = 'hC;

   // assemble the line bits of one frame, bit 0 goes out first
   function automatic frame_t build_frame(input logic [7:0] d, input ctrl_t c);
      frame_t f;
      int     n;
      logic   p;
      f.bits    = '1;
      f.bits[0] = 1'b0;
      n         = 1;
      p         = c.odd;
      for (int i = 0; i < 8; i++) begin
         if (i < 7 || c.eight) begin
            f.bits[n] = d[i];
            p         = p ^ d[i];
            n++;
         end
      end
      if (c.par_en) begin
         f.bits[n] = p;
         n++;
      end
      n++;
      f.len = 4'(n);
      return f;
   endfunction

endpackage

// File: rtl/sport_fifo.sv
`timescale 1ns/1ps
module sport_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sport_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/sport_tick.sv
`timescale 1ns/1ps
module sport_tick #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("sport_tick: DIV must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == CW'(DIV - 1));
   assign tick = !clr && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (wrap)  cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sport_tx.sv
`timescale 1ns/1ps
module sport_tx
   import sport_pkg::*;
#(
   parameter int DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  ctrl_t      ctrl,
   input  logic       q_empty,
   input  logic [7:0] q_data,
   output logic       q_pop,
   output logic       txd,
   output logic       busy
);
   logic [10:0] shreg;
   logic [3:0]  left;
   logic [3:0]  sub;
   logic        tick;
   frame_t      fr;

   sport_tick #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!busy),
      .tick (tick)
   );

   assign fr    = build_frame(q_data, ctrl);
   assign q_pop = !busy && !q_empty;
   assign txd   = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         left  <= '0;
         sub   <= '0;
      end else if (!busy) begin
         if (!q_empty) begin
            shreg <= fr.bits;
            left  <= fr.len;
            sub   <= '0;
            busy  <= 1'b1;
         end
      end else if (tick) begin
         sub <= sub + 1'b1;
         if (sub == 4'd15) begin
            shreg <= {1'b1, shreg[10:1]};
            left  <= left - 1'b1;
            if (left == 4'd1) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sport_rx.sv
`timescale 1ns/1ps
module sport_rx
   import sport_pkg::*;
#(
   parameter int DIV  = 2,
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  ctrl_t      ctrl,
   input  logic       rxd,
   output logic       done,
   output logic [7:0] data,
   output logic       perr,
   output logic       ferr
);
   generate
      if (SYNC < 2) begin : g_bad_sync
         $error("sport_rx: SYNC must be at least 2");
      end
   endgenerate

   logic [SYNC-1:0] sy;
   logic            rxs;
   rx_state_t       state;
   ctrl_t           cfg;
   logic [3:0]      sub, idx, nd;
   logic [7:0]      acc;
   logic            pacc, pe, tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '1;
      else        sy <= {sy[SYNC-2:0], rxd};
   end
   assign rxs = sy[SYNC-1];
   assign nd  = cfg.eight ? 4'd8 : 4'd7;

   sport_tick #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (state == RX_IDLE),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         cfg   <= '0;
         sub   <= '0;
         idx   <= '0;
         acc   <= '0;
         pacc  <= 1'b0;
         pe    <= 1'b0;
         done  <= 1'b0;
         data  <= '0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (!rxs) begin
                  state <= RX_START;
                  cfg   <= ctrl;
                  sub   <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (sub == 4'd7) begin
                     sub <= '0;
                     if (!rxs) begin
                        state <= RX_BITS;
                        idx   <= '0;
                        acc   <= '0;
                        pacc  <= 1'b0;
                        pe    <= 1'b0;
                     end else begin
                        state <= RX_IDLE;
                     end
                  end else begin
                     sub <= sub + 1'b1;
                  end
               end
            end
            RX_BITS: begin
               if (tick) begin
                  sub <= sub + 1'b1;
                  if (sub == 4'd15) begin
                     if (idx < nd) begin
                        acc[idx[2:0]] <= rxs;
                        pacc          <= pacc ^ rxs;
                        idx           <= idx + 1'b1;
                     end else if (cfg.par_en && idx == nd) begin
                        pe  <= pacc ^ rxs ^ cfg.odd;
                        idx <= idx + 1'b1;
                     end else begin
                        done  <= 1'b1;
                        data  <= acc;
                        perr  <= pe;
                        ferr  <= !rxs;
                        state <= RX_IDLE;
                     end
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sport_top.sv
`timescale 1ns/1ps
module sport_top
   import sport_pkg::*;
#(
   parameter int AW    = 4,
   parameter int DEPTH = 16,
   parameter int DIV   = 2,
   parameter int SYNC  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          psel,
   input  logic          penable,
   input  logic          pwrite,
   input  logic [AW-1:0] paddr,
   input  logic [7:0]    pwdata,
   output logic [7:0]    prdata,
   output logic          txd,
   input  logic          rxd,
   output logic          tx_ready,
   output logic          rx_avail
);
   generate
      if (AW < 4) begin : g_bad_aw
         $error("sport_top: AW must be at least 4");
      end
   endgenerate

   ctrl_t      ctrl_q;
   logic [2:0] err_q;
   logic       wr_acc, rd_acc;
   logic       tx_full, tx_empty, tx_pop, tx_busy;
   logic [7:0] tx_head;
   logic       rx_full, rx_empty, rx_pop, rx_done, rx_perr, rx_ferr;
   logic [7:0] rx_head, rx_char;
   logic [2:0] err_new;

   assign wr_acc = psel && penable && pwrite;
   assign rd_acc = psel && penable && !pwrite;
   assign rx_pop = rd_acc && (paddr == AW'(OFS_RXD));

   sport_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk  (clk),
      .rst_n(rst_n),
      .push (wr_acc && (paddr == AW'(OFS_TXD))),
      .wdata(pwdata),
      .pop  (tx_pop),
      .rdata(tx_head),
      .full (tx_full),
      .empty(tx_empty)
   );

   sport_tx #(.DIV(DIV)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl   (ctrl_q),
      .q_empty(tx_empty),
      .q_data (tx_head),
      .q_pop  (tx_pop),
      .txd    (txd),
      .busy   (tx_busy)
   );

   sport_rx #(.DIV(DIV), .SYNC(SYNC)) u_rx (
      .clk  (clk),
      .rst_n(rst_n),
      .ctrl (ctrl_q),
      .rxd  (rxd),
      .done (rx_done),
      .data (rx_char),
      .perr (rx_perr),
      .ferr (rx_ferr)
   );

   sport_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk  (clk),
      .rst_n(rst_n),
      .push (rx_done && !rx_full),
      .wdata(rx_char),
      .pop  (rx_pop),
      .rdata(rx_head),
      .full (rx_full),
      .empty(rx_empty)
   );

   assign err_new = {rx_done && rx_full, rx_done && rx_ferr, rx_done && rx_perr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         err_q  <= '0;
      end else begin
         if (wr_acc && paddr == AW'(OFS_CTL)) ctrl_q <= pwdata[2:0];
         if (rd_acc && paddr == AW'(OFS_ERR)) err_q <= err_new;
         else                                 err_q <= err_q | err_new;
      end
   end

   always_comb begin
      prdata = '0;
      if (paddr == AW'(OFS_RXD))      prdata = rx_empty ? 8'h00 : rx_head;
      else if (paddr == AW'(OFS_ERR)) prdata = {5'b0, err_q};
      else if (paddr == AW'(OFS_CTL)) prdata = {5'b0, ctrl_q};
   end

   assign tx_ready = !tx_full;
   assign rx_avail = !rx_empty;
endmodule

// File: rtl/sport_check.sv
`timescale 1ns/1ps
module sport_check #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          psel,
   input logic          penable,
   input logic          pwrite,
   input logic [AW-1:0] paddr,
   input logic          txd,
   input logic          tx_ready,
   input logic          rx_avail,
   input logic          tx_busy,
   input logic          rx_done,
   input logic [2:0]    ctrl_q,
   input logic [2:0]    err_q
);
   logic wr_tx, wr_ctl, rd_rx, rd_err;
   assign wr_tx  = psel && penable && pwrite  && paddr == AW'('h0);
   assign wr_ctl = psel && penable && pwrite  && paddr == AW'('hC);
   assign rd_rx  = psel && penable && !pwrite && paddr == AW'('h4);
   assign rd_err = psel && penable && !pwrite && paddr == AW'('h8);

   assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   assert_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> !txd);

   assert_txready_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_ready) |-> $past(wr_tx));

   assert_rxavail_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_avail) |-> $past(rd_rx));

   assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_q) |-> $past(wr_ctl));

   assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_err) && !$past(rx_done)) |-> (err_q == 3'b000));

   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_err) |-> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

bind sport_top sport_check #(.AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .psel    (psel),
   .penable (penable),
   .pwrite  (pwrite),
   .paddr   (paddr),
   .txd     (txd),
   .tx_ready(tx_ready),
   .rx_avail(rx_avail),
   .tx_busy (tx_busy),
   .rx_done (rx_done),
   .ctrl_q  (ctrl_q),
   .err_q   (err_q)
);

// File: tb/sport_top_bench.sv
`timescale 1ns/1ps
module sport_top_bench;
   localparam int AW    = 4;
   localparam int DEPTH = 16;
   localparam int DIV   = 2;
   localparam int BIT   = 16 * DIV;
   localparam int FRAME = 11 * BIT;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [7:0]    pwdata = '0;
   logic [7:0]    prdata;
   logic          txd, rxd, tx_ready, rx_avail;
   logic          loop = 1'b1;
   logic          line_drv = 1'b1;
   int            checks = 0, errors = 0;

   assign rxd = loop ? txd : line_drv;

   always #5 clk = ~clk;

   sport_top #(.AW(AW), .DEPTH(DEPTH), .DIV(DIV), .SYNC(2)) u_sport_top (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .txd(txd), .rxd(rxd),
      .tx_ready(tx_ready), .rx_avail(rx_avail)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge clk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   function automatic int frame_len(input logic [2:0] c);
      return 2 + (c[0] ? 8 : 7) + (c[1] ? 1 : 0);
   endfunction

   function automatic logic exp_bit(input logic [7:0] d, input logic [2:0] c, input int k);
      int   nd;
      logic p;
      nd = c[0] ? 8 : 7;
      p  = c[2];
      for (int i = 0; i < nd; i++) p = p ^ d[i];
      if (k == 0) return 1'b0;
      if (k <= nd) return d[k-1];
      if (c[1] && k == nd + 1) return p;
      return 1'b1;
   endfunction

   function automatic logic [7:0] masked(input logic [7:0] d, input logic [2:0] c);
      return c[0] ? d : {1'b0, d[6:0]};
   endfunction

   // drive one frame on rxd by hand; optional wrong parity or short low stop bit
   task automatic send_frame(input logic [7:0] d, input logic [2:0] c,
                             input bit bad_par, input bit bad_stop);
      int n;
      n = frame_len(c);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         line_drv = exp_bit(d, c, k);
         if (bad_par && c[1] && k == n - 2) line_drv = ~line_drv;
         if (bad_stop && k == n - 1) begin
            line_drv = 1'b0;
            repeat (BIT/2 + 8) @(negedge clk);
            line_drv = 1'b1;
            repeat (BIT/2 - 8) @(negedge clk);
         end else begin
            repeat (BIT - 1) @(negedge clk);
         end
      end
      @(negedge clk);
      line_drv = 1'b1;
   endtask

   // read characters until the line stays quiet for three frames
   task automatic collect(input logic [7:0] exp_q[$], input string tag);
      logic [7:0] v;
      int         got, quiet;
      got = 0; quiet = 0;
      while (quiet < 3 * FRAME) begin
         if (rx_avail) begin
            apb_rd(AW'('h4), v);
            if (got < exp_q.size()) check(tag, v, exp_q[got]);
            got++;
            quiet = 0;
         end else begin
            @(negedge clk);
            quiet++;
         end
      end
      check({tag, " count"}, got, exp_q.size());
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [2:0] modes[5];
      logic [7:0] sent[$];
      void'($urandom(32'h1357_2468));
      modes = '{3'b011, 3'b111, 3'b010, 3'b110, 3'b001};

      repeat (5) @(negedge clk);
      #2 check("R12 reset tx_ready", tx_ready, 1);
      check("R12 reset rx_avail", rx_avail, 0);
      check("R12 reset txd idle", txd, 1);
      @(negedge clk);
      rst_n = 1'b1;
      apb_rd(AW'('hC), v); check("R12 R1 ctrl default", v, 8'h00);
      apb_rd(AW'('h8), v); check("R11 err default", v, 8'h00);
      apb_rd(AW'('h4), v); check("R3 empty read", v, 8'h00);

      apb_wr(AW'('hC), 8'hFD); apb_rd(AW'('hC), v); check("R1 ctrl readback", v, 8'h05);
      apb_wr(AW'('hC), 8'h03); apb_rd(AW'('hC), v); check("R1 ctrl readback", v, 8'h03);

      // frame shape on txd: 8 bit even, then 7 bit odd
      loop = 1'b0;
      for (int t = 0; t < 2; t++) begin
         logic [2:0] c;
         logic [7:0] d;
         c = (t == 0) ? 3'b011 : 3'b110;
         d = (t == 0) ? 8'hA5 : 8'hC3;
         apb_wr(AW'('hC), {5'b0, c});
         apb_wr(AW'('h0), d);
         while (txd) @(negedge clk);
         repeat (BIT/2) @(negedge clk);
         for (int k = 0; k < frame_len(c) + 1; k++) begin
            check($sformatf("R6 R7 R8 frame bit %0d mode %0d", k, c), txd, exp_bit(d, c, k));
            repeat (BIT) @(negedge clk);
         end
      end
      loop = 1'b1;
      repeat (2 * FRAME) @(negedge clk);
      apb_rd(AW'('h8), v); check("R11 no error after shape test", v, 8'h00);

      // back-to-back streams in every mode with random bytes
      foreach (modes[m]) begin
         logic [7:0] exp_q[$];
         int tc;
         apb_wr(AW'('hC), {5'b0, modes[m]});
         exp_q.delete();
         tc = 0;
         while (tc < DEPTH + 1) begin
            if (tx_ready) begin
               v = 8'($urandom);
               if (tc == 0) v = 8'hFF;
               apb_wr(AW'('h0), v);
               exp_q.push_back(masked(v, modes[m]));
               tc++;
            end else if (rx_avail) begin
               apb_rd(AW'('h4), v);
               check("R9 R7 stream early", v, exp_q[0]);
               void'(exp_q.pop_front());
            end else @(negedge clk);
         end
         collect(exp_q, $sformatf("R9 R7 R8 stream mode %0d", modes[m]));
         apb_rd(AW'('h8), v); check("R8 R11 stream no error", v, 8'h00);
      end

      // fill the transmit queue, then one extra write is dropped
      apb_wr(AW'('hC), 8'h01);
      sent.delete();
      for (int i = 0; i < DEPTH + 1; i++) begin
         v = 8'($urandom);
         apb_wr(AW'('h0), v);
         sent.push_back(v);
      end
      #1 check("R4 tx_ready low when full", tx_ready, 0);
      apb_wr(AW'('h0), 8'h5A);
      collect(sent, "R2 R3 full queue order");

      // overrun: nobody reads while DEPTH+1 characters arrive
      apb_wr(AW'('hC), 8'h00);
      sent.delete();
      for (int i = 0; i < DEPTH + 1; i++) begin
         v = 8'($urandom);
         apb_wr(AW'('h0), v);
         if (i < DEPTH) sent.push_back({1'b0, v[6:0]});
      end
      repeat ((DEPTH + 2) * FRAME) @(negedge clk);
      apb_rd(AW'('h8), v); check("R11 overrun flag", v, 8'h04);
      apb_rd(AW'('h8), v); check("R11 cleared by read", v, 8'h00);
      collect(sent, "R11 R3 kept after overrun");

      // parity and framing errors injected on the line
      loop = 1'b0;
      apb_wr(AW'('hC), 8'h03);
      send_frame(8'h5A, 3'b011, 1'b1, 1'b0);
      repeat (BIT) @(negedge clk);
      apb_rd(AW'('h8), v); check("R11 parity error flag", v, 8'h01);
      apb_rd(AW'('h4), v); check("R11 char kept on parity error", v, 8'h5A);
      send_frame(8'h3C, 3'b011, 1'b0, 1'b1);
      repeat (2 * BIT) @(negedge clk);
      apb_rd(AW'('h8), v); check("R11 framing error flag", v, 8'h02);
      apb_rd(AW'('h4), v); check("R11 char kept on framing error", v, 8'h3C);
      check("R5 rx_avail after drain", rx_avail, 0);

      // false start: short low pulse
      @(negedge clk); line_drv = 1'b0;
      repeat (BIT/4) @(negedge clk); line_drv = 1'b1;
      repeat (3 * FRAME) @(negedge clk);
      check("R10 false start stores nothing", rx_avail, 0);
      apb_rd(AW'('h8), v); check("R10 false start no error", v, 8'h00);

      // asynchronous reset in the middle of a stream
      loop = 1'b1;
      apb_wr(AW'('hC), 8'h03);
      for (int i = 0; i < 3; i++) apb_wr(AW'('h0), 8'(8'h11 * (i + 1)));
      repeat (FRAME + BIT * 3) @(negedge clk);
      #2 rst_n = 1'b0;
      #1 check("R12 txd idle in reset", txd, 1);
      check("R12 rx queue emptied", rx_avail, 0);
      check("R12 tx queue emptied", tx_ready, 1);
      @(negedge clk); rst_n = 1'b1;
      apb_rd(AW'('hC), v); check("R12 ctrl back to 0", v, 8'h00);
      apb_rd(AW'('h8), v); check("R12 err cleared", v, 8'h00);
      repeat (3 * FRAME) @(negedge clk);
      check("R12 nothing sent after reset", rx_avail, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule